// File: doc/BRIEF.md
# Fetch Stall Stash Buffer

This block sits in the fetch stage between an instruction cache that cannot be stalled and the decoder. The cache reads one address per cycle from a synchronous memory and has no hold path. When the decoder raises its stall, the front end has already moved on by one address, and the cache is already producing that next instruction. Without help, that instruction would be lost. The stash buffer saves it into a single-entry register while the stall lasts. On the first cycle after release, it hands the saved word to the decoder in place of the live cache output.

The registered output to the decoder holds steady for the whole stall. A flush, used on a redirect, empties both the output and the stash in one cycle. A small two-state controller tracks whether the stash holds a word. In state `ST_FLOW` the stash is empty and cache output passes through. In state `ST_HELD` the stash is full and the decoder's next word comes from the stash. There are three named transitions. `CAPTURE` goes from ST_FLOW to ST_HELD on a stall with valid cache output. `RELEASE` goes from ST_HELD to ST_FLOW when the stall drops. `FLUSH` goes from either state to ST_FLOW.

Top module: `fetch_stash`

## Requirements
- R1: After reset the decoder output valid is 0 and the stash is empty. With no stall and no valid cache output, valid stays 0.
- R2: With no stall, no flush and an empty stash, the output registers take the cache valid, address and instruction at the next clock edge.
- R3: In a cycle with stall high and flush low, the output valid, address and instruction do not change at the next edge.
- R4: In a cycle with stall high, an empty stash and valid cache output, the cache word is captured (CAPTURE). In the first following cycle with stall low, the output at the next edge is the stashed word, and the live cache output of that cycle is discarded (RELEASE).
- R5: After a stashed word has been delivered, the stash is empty and the next unstalled cycle passes the cache output through.
- R6: An invalid cache output during a stall is not stashed. On release, the output takes the live cache word of the release cycle.
- R7: While the stash is full and the stall continues, further cache outputs are ignored. The first captured word is the one delivered.
- R8: A flush drives output valid to 0 at the next edge, whether or not stall is high.
- R9: A flush empties the stash (FLUSH). After it, the next unstalled cycle passes the live cache output through rather than any earlier stashed word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ic_valid | input | 1 | Cache output valid |
| ic_addr | input | ADDR_W | Address of the cache word |
| ic_insn | input | INSN_W | Instruction word from the cache |
| dec_stall | input | 1 | Stall request from the decoder |
| flush | input | 1 | Redirect; discards output and stash |
| dec_valid | output | 1 | Instruction valid to the decoder |
| dec_addr | output | ADDR_W | Instruction address to the decoder |
| dec_insn | output | INSN_W | Instruction word to the decoder |

## Verification
A controller stuck in ST_FLOW loses the overrun word. This shows one cycle after release: the address sequence at the decoder skips one step. A controller stuck in ST_HELD repeats a stale word instead of the live cache output in the cycle after an unstall. A stash that misses flush shows as an old address reappearing right after a redirect. An output register that moves during a stall shows a changed address at the very next edge. Every fault of this kind reaches the ports within two cycles of its cause.

// File: rtl/fetch_stash_pkg.sv
package fetch_stash_pkg;
    typedef enum logic [0:0] {
        ST_FLOW = 1'b0,
        ST_HELD = 1'b1
    } stash_state_t;
endpackage

// File: rtl/fetch_stash_ctrl.sv
module fetch_stash_ctrl
    import fetch_stash_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ic_valid,
    input  logic dec_stall,
    input  logic flush,
    output logic capture_en,
    output logic use_stash,
    output logic stash_full
);
    stash_state_t state_q;
    stash_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: CAPTURE, RELEASE, FLUSH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW: begin
                if (!flush && dec_stall && ic_valid) begin
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (flush || !dec_stall) begin
                    state_d = ST_FLOW;
                end
            end
            default: state_d = ST_FLOW;
        endcase
    end

    // Outputs
    always_comb begin
        capture_en = 1'b0;
        use_stash  = 1'b0;
        stash_full = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                capture_en = !flush && dec_stall && ic_valid;
            end
            ST_HELD: begin
                use_stash  = 1'b1;
                stash_full = 1'b1;
            end
            default: begin
                capture_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fetch_stash_store.sv
module fetch_stash_store #(
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              capture_en,
    input  logic [ADDR_W-1:0] ic_addr,
    input  logic [INSN_W-1:0] ic_insn,
    output logic [ADDR_W-1:0] st_addr,
    output logic [INSN_W-1:0] st_insn
);
    localparam int WORD_W = ADDR_W + INSN_W;

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (capture_en) begin
            word_q <= {ic_addr, ic_insn};
        end
    end

    assign st_addr = word_q[WORD_W-1:INSN_W];
    assign st_insn = word_q[INSN_W-1:0];
endmodule

// File: rtl/fetch_stash_outreg.sv
module fetch_stash_outreg #(
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_stall,
    input  logic              flush,
    input  logic              use_stash,
    input  logic              ic_valid,
    input  logic [ADDR_W-1:0] ic_addr,
    input  logic [INSN_W-1:0] ic_insn,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [INSN_W-1:0] st_insn,
    output logic              dec_valid,
    output logic [ADDR_W-1:0] dec_addr,
    output logic [INSN_W-1:0] dec_insn
);
    logic              nxt_valid;
    logic [ADDR_W-1:0] nxt_addr;
    logic [INSN_W-1:0] nxt_insn;

    always_comb begin
        if (use_stash) begin
            nxt_valid = 1'b1;
            nxt_addr  = st_addr;
            nxt_insn  = st_insn;
        end else begin
            nxt_valid = ic_valid;
            nxt_addr  = ic_addr;
            nxt_insn  = ic_insn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
        end else if (flush) begin
            dec_valid <= 1'b0;
        end else if (!dec_stall) begin
            dec_valid <= nxt_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!flush && !dec_stall) begin
            dec_addr <= nxt_addr;
            dec_insn <= nxt_insn;
        end
    end
endmodule

// File: rtl/fetch_stash.sv
module fetch_stash #(
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ic_valid,
    input  logic [ADDR_W-1:0] ic_addr,
    input  logic [INSN_W-1:0] ic_insn,
    input  logic              dec_stall,
    input  logic              flush,
    output logic              dec_valid,
    output logic [ADDR_W-1:0] dec_addr,
    output logic [INSN_W-1:0] dec_insn
);
    logic              capture_en;
    logic              use_stash;
    logic              stash_full;
    logic [ADDR_W-1:0] st_addr;
    logic [INSN_W-1:0] st_insn;

    fetch_stash_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ic_valid   (ic_valid),
        .dec_stall  (dec_stall),
        .flush      (flush),
        .capture_en (capture_en),
        .use_stash  (use_stash),
        .stash_full (stash_full)
    );

    fetch_stash_store #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_store (
        .clk        (clk),
        .capture_en (capture_en),
        .ic_addr    (ic_addr),
        .ic_insn    (ic_insn),
        .st_addr    (st_addr),
        .st_insn    (st_insn)
    );

    fetch_stash_outreg #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_stall  (dec_stall),
        .flush      (flush),
        .use_stash  (use_stash),
        .ic_valid   (ic_valid),
        .ic_addr    (ic_addr),
        .ic_insn    (ic_insn),
        .st_addr    (st_addr),
        .st_insn    (st_insn),
        .dec_valid  (dec_valid),
        .dec_addr   (dec_addr),
        .dec_insn   (dec_insn)
    );
endmodule

// File: rtl/fetch_stash_chk.sv
module fetch_stash_chk #(
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ic_valid,
    input logic [ADDR_W-1:0] ic_addr,
    input logic [INSN_W-1:0] ic_insn,
    input logic              dec_stall,
    input logic              flush,
    input logic              dec_valid,
    input logic [ADDR_W-1:0] dec_addr,
    input logic [INSN_W-1:0] dec_insn,
    input logic              stash_full,
    input logic [ADDR_W-1:0] st_addr
);
    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_stall && !flush && !stash_full) |=>
            (dec_valid == $past(ic_valid)) && (dec_addr == $past(ic_addr))
            && (dec_insn == $past(ic_insn)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall && !flush && $past(rst_n)) |=>
            $stable(dec_valid) && $stable(dec_addr) && $stable(dec_insn));

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall && !flush && !stash_full && ic_valid) |=>
            stash_full && (st_addr == $past(ic_addr)));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_stall && !flush && stash_full) |=>
            dec_valid && (dec_addr == $past(st_addr)) && !stash_full);

    assert_skip_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall && !flush && !stash_full && !ic_valid) |=> !stash_full);

    assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall && !flush && stash_full) |=> stash_full && $stable(st_addr));

    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !dec_valid);

    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !stash_full);
endmodule

bind fetch_stash fetch_stash_chk #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ic_valid   (ic_valid),
    .ic_addr    (ic_addr),
    .ic_insn    (ic_insn),
    .dec_stall  (dec_stall),
    .flush      (flush),
    .dec_valid  (dec_valid),
    .dec_addr   (dec_addr),
    .dec_insn   (dec_insn),
    .stash_full (stash_full),
    .st_addr    (st_addr)
);

// File: tb/fetch_stash_tb.sv
module fetch_stash_tb;
    localparam int AW = 32;
    localparam int IW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ic_valid;
    logic [AW-1:0] ic_addr;
    logic [IW-1:0] ic_insn;
    logic          dec_stall;
    logic          flush;
    logic          dec_valid;
    logic [AW-1:0] dec_addr;
    logic [IW-1:0] dec_insn;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fetch_stash #(.ADDR_W(AW), .INSN_W(IW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ic_valid  (ic_valid),
        .ic_addr   (ic_addr),
        .ic_insn   (ic_insn),
        .dec_stall (dec_stall),
        .flush     (flush),
        .dec_valid (dec_valid),
        .dec_addr  (dec_addr),
        .dec_insn  (dec_insn)
    );

    function automatic logic [IW-1:0] insn_of(input logic [AW-1:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // Drive one cycle's inputs, then wait to the next falling edge
    task automatic cyc(input bit st, input bit fl, input bit v, input logic [AW-1:0] a);
        dec_stall = st;
        flush     = fl;
        ic_valid  = v;
        ic_addr   = a;
        ic_insn   = insn_of(a);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input bit ev, input logic [AW-1:0] ea);
        bit bad;
        n_chk++;
        bad = (dec_valid !== ev);
        if (ev && ((dec_addr !== ea) || (dec_insn !== insn_of(ea)))) bad = 1'b1;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: valid=%0b addr=%h insn=%h expected valid=%0b addr=%h insn=%h",
                     req, dec_valid, dec_addr, dec_insn, ev, ea, insn_of(ea));
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        cyc(0, 0, 1, 32'h0000_0040);
        cyc(0, 0, 1, 32'h0000_0044);
        chk("R1 reset valid", 0, '0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 32'h0000_0048);
        chk("R1 idle after reset", 0, '0);
    endtask

    task automatic t_pass;
        cyc(0, 0, 1, 32'h0000_0010); chk("R2 pass first", 1, 32'h0000_0010);
        cyc(0, 0, 1, 32'h0000_0014); chk("R2 pass second", 1, 32'h0000_0014);
        cyc(0, 0, 0, 32'h0000_0018); chk("R2 pass invalid", 0, '0);
    endtask

    task automatic t_stall_capture;
        cyc(0, 0, 1, 32'h0000_0100); chk("R2 before stall", 1, 32'h0000_0100);
        cyc(1, 0, 1, 32'h0000_0104); chk("R3 hold during stall", 1, 32'h0000_0100);
        cyc(0, 0, 1, 32'h0000_0108); chk("R4 stash delivered", 1, 32'h0000_0104);
        cyc(0, 0, 1, 32'h0000_010C); chk("R5 back to pass", 1, 32'h0000_010C);
    endtask

    task automatic t_stall_invalid;
        cyc(0, 0, 1, 32'h0000_0200); chk("R2 before stall", 1, 32'h0000_0200);
        cyc(1, 0, 0, 32'h0000_0DEC); chk("R3 hold invalid stall", 1, 32'h0000_0200);
        cyc(0, 0, 1, 32'h0000_0204); chk("R6 live word on release", 1, 32'h0000_0204);
    endtask

    task automatic t_long_stall;
        cyc(0, 0, 1, 32'h0000_0300); chk("R2 before stall", 1, 32'h0000_0300);
        cyc(1, 0, 1, 32'h0000_0304); chk("R3 long stall 1", 1, 32'h0000_0300);
        cyc(1, 0, 1, 32'h0000_0308); chk("R3 long stall 2", 1, 32'h0000_0300);
        cyc(1, 0, 1, 32'h0000_030C); chk("R3 long stall 3", 1, 32'h0000_0300);
        cyc(0, 0, 1, 32'h0000_0310); chk("R7 first capture kept", 1, 32'h0000_0304);
        cyc(0, 0, 1, 32'h0000_0314); chk("R5 pass after release", 1, 32'h0000_0314);
    endtask

    task automatic t_flush;
        cyc(0, 0, 1, 32'h0000_0400); chk("R2 before flush", 1, 32'h0000_0400);
        cyc(0, 1, 1, 32'h0000_0404); chk("R8 flush clears valid", 0, '0);
        cyc(0, 0, 1, 32'h0000_0408); chk("R2 after flush", 1, 32'h0000_0408);
    endtask

    task automatic t_flush_stalled;
        cyc(0, 0, 1, 32'h0000_0500); chk("R2 before stall", 1, 32'h0000_0500);
        cyc(1, 0, 1, 32'h0000_0504); chk("R3 hold before flush", 1, 32'h0000_0500);
        cyc(1, 1, 1, 32'h0000_0508); chk("R8 flush beats stall", 0, '0);
        cyc(0, 0, 1, 32'h0000_050C); chk("R9 stash discarded", 1, 32'h0000_050C);
    endtask

    initial begin
        rst_n     = 1'b0;
        dec_stall = 1'b0;
        flush     = 1'b0;
        ic_valid  = 1'b0;
        ic_addr   = '0;
        ic_insn   = '0;
        @(negedge clk);
        t_reset();
        t_pass();
        t_stall_capture();
        t_stall_invalid();
        t_long_stall();
        t_flush();
        t_flush_stalled();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule